// File: doc/BRIEF.md
# SPI slave ring-buffer transmitter

This block is an SPI slave that answers a master with bytes taken from a small circular transmit store, and delivers whatever the master shifts in at the same time. Software, or a neighbouring block, places bytes through a parallel write port. Each byte frame the master clocks out takes the next unsent byte from the ring. The serial timing is clock polarity 0 with sampling on the second edge. MISO changes on the rising SCLK edge, and MOSI is captured on the falling edge.

The transmitter never stalls. When no unsent byte is left, the read position stays on the slot after the last one sent. The old content of that slot goes out again on every frame until a new byte is written there. That byte is then sent on the next frame, and normal advance resumes. A half-empty flag tells the producer when to top the ring up. A sticky overflow flag reports writes that were dropped because the ring was full. A disable input keeps MISO undriven.

SCLK, the active-low select and MOSI are brought into the system clock through two-flop synchronisers, followed by edge detection. The system clock must run at least eight times faster than SCLK, so that the synchroniser latency stays inside half an SCLK period.

Top module: `ringtx_spi_slave`

## Requirements
- R1: Bytes that have been written but not yet sent go out in write order, one per frame. Each byte is sent MSB first, and each bit is presented on MISO after a rising SCLK edge while select is low.
- R2: After reset, every ring slot holds 0x00, so frames with no prior write send 0x00.
- R3: After the last unsent byte has gone out, the read position sits on the following slot. Every later frame sends that slot's stored content again, and the read position does not move until the slot is written.
- R4: A byte written into the slot where the read position is parked goes out on the next frame. Later frames then continue in write order.
- R5: Read and write positions wrap from slot 7 to slot 0. The ring has eight slots.
- R6: half_empty is high exactly when four or fewer unsent bytes remain. It is high after reset.
- R7: A write while eight bytes are unsent is dropped and sets overflow. overflow stays high until reset and is low after reset.
- R8: After each completed 8-bit frame, rx_data holds the MOSI bits with the first bit as the MSB, and rx_valid pulses high for exactly one cycle.
- R9: spi_miso_oe and spi_miso are low while tx_disable is high or select is high. The ring still advances on frames that occur while tx_disable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from master, idle low |
| spi_ssel_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| tx_disable | input | 1 | High keeps MISO undriven |
| wr_en | input | 1 | Write strobe for a transmit byte |
| wr_data | input | 8 | Transmit byte |
| half_empty | output | 1 | Four or fewer unsent bytes remain |
| overflow | output | 1 | Sticky: a write was dropped while the ring was full |
| rx_data | output | 8 | Last byte received from the master |
| rx_valid | output | 1 | One-cycle strobe when rx_data updates |

## Verification
Several properties are checked on every cycle. The count of unsent bytes never exceeds eight. Equal read and write positions go with an empty count. The read position holds still while the ring is empty and no write arrives. overflow stays set once raised, half_empty follows the count, and rx_valid never lasts two cycles. While tx_disable is high, the MISO driver stays off. Other behaviour only the bench scenarios can show: the exact byte sequence on MISO during underrun replay and after a write to the parked slot, pointer wrap, the dropped write not reaching the wire, and the received byte values.

// File: rtl/ringtx_pkg.sv
package ringtx_pkg;
  localparam int unsigned DEF_DEPTH  = 8;
  localparam int unsigned DEF_DATA_W = 8;

  // Synchronised serial-side events, one system clock wide
  typedef struct packed {
    logic active;  // select asserted
    logic rise;    // SCLK rising edge seen
    logic fall;    // SCLK falling edge seen
    logic din;     // MOSI aligned with the edges
  } spi_evt_t;
endpackage

// File: rtl/ringtx_sync.sv
module ringtx_sync
  import ringtx_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk,
  input  logic     ssel_n,
  input  logic     mosi,
  output spi_evt_t evt
);
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] ssel_p;
  logic [STAGES-1:0] mosi_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      ssel_p <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk};
      ssel_p <= {ssel_p[STAGES-2:0], ssel_n};
      mosi_p <= {mosi_p[STAGES-2:0], mosi};
    end
  end

  always_comb begin
    evt.active = ~ssel_p[STAGES-1];
    evt.rise   = sclk_p[STAGES-1] & ~sclk_p[STAGES];
    evt.fall   = ~sclk_p[STAGES-1] & sclk_p[STAGES];
    evt.din    = mosi_p[STAGES-1];
  end
endmodule

// File: rtl/ringtx_ring.sv
module ringtx_ring #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              half_empty,
  output logic              overflow
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned HALF  = DEPTH / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count, count_n;
  logic              wr_acc, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_acc  = wr_en && (count != CNT_W'(DEPTH));
    pop     = pop_req && (count != '0);  // empty: park and replay
    count_n = count + CNT_W'(wr_acc) - CNT_W'(pop);
    rd_data = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_acc) begin
      mem[wr_ptr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      half_empty <= 1'b1;
      overflow   <= 1'b0;
    end else begin
      if (wr_acc) wr_ptr <= bump(wr_ptr);
      if (pop)    rd_ptr <= bump(rd_ptr);
      count      <= count_n;
      half_empty <= (count_n <= CNT_W'(HALF));
      if (wr_en && !wr_acc) overflow <= 1'b1;
    end
  end

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  a_r5_empty_ptrs: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |-> (rd_ptr == wr_ptr));
  a_r3_parked: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !wr_en) |=> $stable(rd_ptr));
  a_r6_half: assert property (@(posedge clk) disable iff (rst)
    half_empty == (count <= CNT_W'(HALF)));
endmodule

// File: rtl/ringtx_shifter.sv
module ringtx_shifter
  import ringtx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  spi_evt_t          evt,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_disable,
  output logic              load,
  output logic              miso,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int unsigned BC_W = $clog2(DATA_W);

  logic [BC_W-1:0]   bitcnt;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              miso_bit;

  always_comb load = evt.active && evt.rise && (bitcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt   <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      miso_bit <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      miso_oe  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      miso_oe  <= evt.active && !tx_disable;
      if (!evt.active) begin
        bitcnt <= '0;
      end else begin
        if (load) begin
          tx_sh    <= tx_byte;
          miso_bit <= tx_byte[DATA_W-1];
        end else if (evt.rise) begin
          tx_sh    <= tx_sh << 1;
          miso_bit <= tx_sh[DATA_W-2];
        end
        if (evt.fall) begin
          rx_sh <= {rx_sh[DATA_W-2:0], evt.din};
          if (bitcnt == BC_W'(DATA_W - 1)) begin
            bitcnt   <= '0;
            rx_data  <= {rx_sh[DATA_W-2:0], evt.din};
            rx_valid <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb miso = miso_bit & miso_oe;

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  a_r9_disable_oe: assert property (@(posedge clk) disable iff (rst)
    tx_disable |=> !miso_oe);
  a_r9_disable_line: assert property (@(posedge clk) disable iff (rst)
    tx_disable |=> !miso);
endmodule

// File: rtl/ringtx_spi_slave.sv
module ringtx_spi_slave
  import ringtx_pkg::*;
#(
  parameter int unsigned DEPTH       = DEF_DEPTH,
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_ssel_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              tx_disable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              half_empty,
  output logic              overflow,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  spi_evt_t          evt;
  logic              load;
  logic [DATA_W-1:0] tx_byte;

  ringtx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .ssel_n(spi_ssel_n),
    .mosi(spi_mosi), .evt(evt)
  );

  ringtx_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) ring_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pop_req(load), .rd_data(tx_byte), .half_empty(half_empty),
    .overflow(overflow)
  );

  ringtx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .evt(evt), .tx_byte(tx_byte),
    .tx_disable(tx_disable), .load(load), .miso(spi_miso),
    .miso_oe(spi_miso_oe), .rx_data(rx_data), .rx_valid(rx_valid)
  );
endmodule

// File: tb/ringtx_spi_slave_tb_top.sv
module ringtx_spi_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, ssel_n = 1'b1, mosi = 1'b0, dis = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic miso, miso_oe, half_empty, overflow, rx_valid;
  logic [7:0] rx_data;

  always #2.5 clk = ~clk;

  ringtx_spi_slave dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_ssel_n(ssel_n),
    .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .tx_disable(dis), .wr_en(wr_en), .wr_data(wr_data),
    .half_empty(half_empty), .overflow(overflow), .rx_data(rx_data),
    .rx_valid(rx_valid)
  );

  int vectors = 0, fails = 0, pulses = 0;
  bit done = 0;
  logic [7:0] m_mem [8];
  int m_rd = 0, m_wr = 0, m_cnt = 0;
  bit m_ovf = 0;

  always @(posedge clk) if (!rst && rx_valid) pulses++;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_half(int c);
    return c <= 4;
  endfunction

  task automatic write_byte(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (m_cnt < 8) begin
      m_mem[m_wr] = d; m_wr = (m_wr + 1) % 8; m_cnt++;
    end else m_ovf = 1;
  endtask

  task automatic frame(logic [7:0] tx);
    logic [7:0] got, exp;
    string tag;
    int p0;
    bit oe_bad;
    p0 = pulses;
    exp = m_mem[m_rd];
    if (m_cnt == 0) tag = "R3";
    else if (m_rd == 7) tag = "R5";
    else tag = "R1";
    if (m_cnt > 0) begin m_rd = (m_rd + 1) % 8; m_cnt--; end
    got = '0; oe_bad = 0;
    ssel_n = 1'b0; #40;
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b]; sclk = 1'b1; #40;
      got[b] = miso;
      if (miso_oe !== !dis) oe_bad = 1;
      sclk = 1'b0; #40;
    end
    #40;
    if (dis) begin
      check("R9 miso low while disabled", got, 8'h00);
      check("R9 oe low while disabled", oe_bad, 0);
    end else begin
      check(tag, got, exp);
      check("R9 oe during frame", oe_bad, 0);
    end
    check("R8 rx_data", rx_data, tx);
    check("R8 one pulse per frame", pulses - p0, 1);
    ssel_n = 1'b1; #80;
    check("R9 oe low when deselected", miso_oe, 0);
    check("R6 half_empty", half_empty, exp_half(m_cnt));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    #20;
    check("R6 reset half_empty", half_empty, 1);
    check("R7 reset overflow", overflow, 0);
    check("R9 reset oe", miso_oe, 0);
    // R2: no writes, zeros go out
    frame(8'hA5);
    check("R2 zero slot", m_mem[m_rd], 8'h00);
    // R1/R3: five bytes then underrun replay
    foreach (m_mem[i]) ;
    write_byte(8'h74); write_byte(8'h65); write_byte(8'h73);
    write_byte(8'h74); write_byte(8'h0A);
    #20 check("R6 five unsent", half_empty, 0);
    for (int i = 0; i < 10; i++) frame(8'(i * 17 + 3));
    // R4: write into parked slot
    write_byte(8'h3C);
    frame(8'h11);
    frame(8'h22);
    // R7: fill and overflow
    for (int i = 0; i < 9; i++) write_byte(8'(8'h80 + i));
    #20;
    check("R7 overflow set", overflow, 1);
    check("R7 overflow model", m_ovf, 1);
    check("R6 full", half_empty, 0);
    for (int i = 0; i < 4; i++) frame(8'hC3);
    // R9: disabled frame still advances ring
    dis = 1'b1;
    frame(8'h5A);
    dis = 1'b0;
    for (int i = 0; i < 5; i++) frame(8'h0F);
    check("R7 overflow sticky", overflow, 1);
    // random mix (R5 wrap covered)
    void'($urandom(32'd1234));
    for (int it = 0; it < 150; it++) begin
      int nw, nf;
      nw = $urandom_range(0, 3);
      nf = $urandom_range(0, 2);
      for (int k = 0; k < nw; k++) write_byte(8'($urandom));
      for (int k = 0; k < nf; k++) frame(8'($urandom));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule